// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block brings a hung I2C bus back to idle without software toggling pins. When it gets a request, it first waits for SCL to be released, in case another agent is stretching the clock. It then clocks SCL at a slow, even pace for as long as a slave keeps SDA low. Once SDA is free, it drives a START followed by a STOP. Last, it watches SCL through a quiet window. Any SCL activity in that window sends the whole procedure back to its first step. A single deadline, counted in microseconds from the request, bounds the entire attempt.

The two bus lines are open-drain. The block outputs a pull-low enable for each line and reads back the resolved line level. A microsecond tick is derived from the system clock through `CLK_PER_US`. Step spacing, quiet window and deadline are parameters given in microseconds. The outcome is held on `done` or `fail` until the next accepted request.

Top module: `i2c_bus_recover`

## Requirements
- R1: After reset, `scl_drive_low`, `sda_drive_low`, `busy`, `done` and `fail` are all 0.
- R2: A `recover_req` sampled high while not busy makes `busy` 1 on the next cycle and clears `done` and `fail`. While SCL reads low in the first step, both lines stay released and the block waits.
- R3: Every timed step (settle, clock low, clock high, and the three START/STOP steps) lasts exactly `STEP_US*CLK_PER_US` clock cycles.
- R4: SCL is seen high, then one settle step passes, then SDA is sampled. If SDA reads low, SCL is driven low for one step and released for one step. The block then waits for SCL high again, and a new settle step is followed by a new SDA sample.
- R5: When the settle step ends with SDA high, three steps follow. First SDA alone is driven low. Next both lines are driven low. Then SCL is released while SDA is still held low. SDA is released after that.
- R6: After the STOP, SCL is watched for `QUIET_US*CLK_PER_US` cycles. If SCL reads low in any of those cycles, the block returns to the first step with both lines released.
- R7: If SCL reads high for the whole quiet window, `done` goes to 1 and `busy` to 0. Both lines are released, and `done` stays 1 until the next accepted request.
- R8: Exactly `DEADLINE_US*CLK_PER_US` busy cycles after acceptance, an attempt that has not succeeded ends with `fail` at 1, `busy` at 0 and both lines released. `done` and `fail` are never 1 together.
- R9: A `recover_req` raised while `busy` is 1 has no effect on the sequence or its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| recover_req | input | 1 | Start a recovery attempt (sampled while idle) |
| scl_in | input | 1 | Resolved SCL line level |
| sda_in | input | 1 | Resolved SDA line level |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | Attempt in progress |
| done | output | 1 | Last attempt restored the bus |
| fail | output | 1 | Last attempt hit the deadline |

## Verification
The bench targets several corner cases. The first is a slave that holds SDA for a known number of clock pulses: a design that skips the post-pulse SDA sample, or that counts pulses wrongly, emits the wrong number of SCL falls. The second is a brief SCL pull inside the quiet window: a design that ignores it reports success with one START instead of two. The third is SCL held low from the start, and the fourth is SDA held low for good. In both, a deadline that is off by a cycle, or that restarts on each retry, shows up as the wrong busy length. A late duplicate request is also applied; a design that honours it stretches the run beyond its nominal length.

// File: rtl/i2c_recover_pkg.sv
// Package: states of the bus recovery sequencer and the line-drive
// decode per state. Assumes the state set is only used by the sequencer.
package i2c_recover_pkg;

    typedef enum logic [3:0] {
        RS_IDLE,      // lines released, waiting for a request
        RS_WAIT_SCL,  // lines released, waiting for SCL high
        RS_SETTLE,    // one step after SCL high, then sample SDA
        RS_CLK_LO,    // recovery pulse, SCL low
        RS_CLK_HI,    // recovery pulse, SCL released
        RS_SDA_LO,    // START: SDA low while SCL high
        RS_SCL_LO,    // both low
        RS_SCL_HI,    // SCL released, SDA still low
        RS_QUIET      // both released, watching SCL
    } rec_state_e;

    // Returns 1 where the state pulls SCL low.
    function automatic logic state_pulls_scl(rec_state_e s);
        return (s == RS_CLK_LO) || (s == RS_SCL_LO);
    endfunction

    // Returns 1 where the state pulls SDA low.
    function automatic logic state_pulls_sda(rec_state_e s);
        return (s == RS_SDA_LO) || (s == RS_SCL_LO) || (s == RS_SCL_HI);
    endfunction

endpackage

// File: rtl/rec_phase_timer.sv
// Cycle counter for the time spent in one sequencer state.
// Assumes: clr is asserted on the edge that enters a new state, so the
// count reads 0 in the first cycle of every state. Saturates at all ones.
module rec_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);

    // Count cycles in the current state, restart on a state change.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (!(&cnt)) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/rec_us_deadline.sv
// Overall attempt deadline. A microsecond tick is derived from the clock
// while run is high, and hit pulses in the cycle that completes
// DEADLINE_US microseconds of run time.
// Assumes: run stays high for a whole attempt and drops the cycle after hit.
module rec_us_deadline #(
    parameter int CLK_PER_US  = 50,
    parameter int DEADLINE_US = 300000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic hit
);

    localparam int UW = $clog2(DEADLINE_US + 1);

    logic          us_tick;
    logic [UW-1:0] us_q;

    generate
        if (CLK_PER_US == 1) begin : g_direct
            assign us_tick = run;
        end else begin : g_prescale
            localparam int PW = $clog2(CLK_PER_US);
            logic [PW-1:0] pre_q;

            // Divide the clock down to one tick per microsecond of run time.
            always_ff @(posedge clk) begin
                if (!rst_n || !run) begin
                    pre_q <= '0;
                end else if (pre_q == PW'(CLK_PER_US - 1)) begin
                    pre_q <= '0;
                end else begin
                    pre_q <= pre_q + 1'b1;
                end
            end

            assign us_tick = run && (pre_q == PW'(CLK_PER_US - 1));
        end
    endgenerate

    // Count elapsed microseconds of the current attempt.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            us_q <= '0;
        end else if (us_tick) begin
            us_q <= us_q + 1'b1;
        end
    end

    assign hit = us_tick && (us_q == UW'(DEADLINE_US - 1));

    AST_DEADLINE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !run); // R8

endmodule

// File: rtl/i2c_bus_recover.sv
// I2C bus recovery sequencer (top). Waits for SCL release, pulses SCL while
// SDA is held low, issues START then STOP, and confirms a quiet SCL.
// Assumes: scl_in/sda_in are already synchronised to clk; the pad turns a
// drive_low of 0 into a released (pulled-up) line.
module i2c_bus_recover
    import i2c_recover_pkg::*;
#(
    parameter int CLK_PER_US  = 50,
    parameter int STEP_US     = 10,
    parameter int QUIET_US    = 50,
    parameter int DEADLINE_US = 300000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic recover_req,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_drive_low,
    output logic sda_drive_low,
    output logic busy,
    output logic done,
    output logic fail
);

    localparam int STEP_CYC  = STEP_US * CLK_PER_US;
    localparam int QUIET_CYC = QUIET_US * CLK_PER_US;
    localparam int TMR_MAX   = (STEP_CYC > QUIET_CYC) ? STEP_CYC : QUIET_CYC;
    localparam int TW        = $clog2(TMR_MAX + 1);

    rec_state_e     state_q, state_n;
    logic [TW-1:0]  tmr_cnt;
    logic           step_end, quiet_end;
    logic           dl_hit;
    logic           accept, success;

    assign step_end  = (tmr_cnt == TW'(STEP_CYC - 1));
    assign quiet_end = (tmr_cnt == TW'(QUIET_CYC - 1));
    assign busy      = (state_q != RS_IDLE);
    assign accept    = (state_q == RS_IDLE) && recover_req;
    assign success   = (state_q == RS_QUIET) && scl_in && quiet_end && !dl_hit;

    rec_phase_timer #(
        .W (TW)
    ) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_n != state_q),
        .cnt   (tmr_cnt)
    );

    rec_us_deadline #(
        .CLK_PER_US  (CLK_PER_US),
        .DEADLINE_US (DEADLINE_US)
    ) u_deadline (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .hit   (dl_hit)
    );

    // Choose the next step of the recovery sequence.
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            RS_IDLE:     if (recover_req) state_n = RS_WAIT_SCL;
            RS_WAIT_SCL: if (scl_in)      state_n = RS_SETTLE;
            RS_SETTLE:   if (step_end)    state_n = sda_in ? RS_SDA_LO : RS_CLK_LO;
            RS_CLK_LO:   if (step_end)    state_n = RS_CLK_HI;
            RS_CLK_HI:   if (step_end)    state_n = RS_WAIT_SCL;
            RS_SDA_LO:   if (step_end)    state_n = RS_SCL_LO;
            RS_SCL_LO:   if (step_end)    state_n = RS_SCL_HI;
            RS_SCL_HI:   if (step_end)    state_n = RS_QUIET;
            RS_QUIET: begin
                if (!scl_in)        state_n = RS_WAIT_SCL;
                else if (quiet_end) state_n = RS_IDLE;
            end
            default:                state_n = RS_IDLE;
        endcase
        if (dl_hit) begin
            state_n = RS_IDLE;
        end
    end

    // Hold the current step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // Register the open-drain enables from the step being entered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_drive_low <= 1'b0;
            sda_drive_low <= 1'b0;
        end else begin
            scl_drive_low <= state_pulls_scl(state_n);
            sda_drive_low <= state_pulls_sda(state_n);
        end
    end

    // Keep the outcome of the last attempt until a new one is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            done <= 1'b0;
            fail <= 1'b0;
        end else if (dl_hit) begin
            fail <= 1'b1;
        end else if (success) begin
            done <= 1'b1;
        end
    end

    AST_REQ_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && recover_req) |=> (busy && !done && !fail)); // R2

    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q inside {RS_SETTLE, RS_CLK_LO, RS_CLK_HI, RS_SDA_LO, RS_SCL_LO, RS_SCL_HI})
            |-> (tmr_cnt < TW'(STEP_CYC))); // R3

    AST_START_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drive_low) |-> !scl_drive_low); // R5

    AST_QUIET_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_QUIET && !scl_in && !dl_hit) |=>
            (state_q == RS_WAIT_SCL && !scl_drive_low && !sda_drive_low)); // R6

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_drive_low && !sda_drive_low)); // R7

    AST_OUTCOME_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail)); // R8

    AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && recover_req && !dl_hit && !success) |=> busy); // R9

endmodule

// File: tb/sim_i2c_bus_recover.sv
module sim_i2c_bus_recover;

    localparam int CPU     = 2;
    localparam int SU      = 10;
    localparam int QU      = 50;
    localparam int DU      = 2000;
    localparam int STEP_C  = SU * CPU;
    localparam int QUIET_C = QU * CPU;
    localparam int DL_C    = DU * CPU;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic recover_req = 1'b0;
    logic ext_scl_hold = 1'b0;
    logic stuck_forever = 1'b0;
    int   stuck_left = 0;
    logic scl_drive_low, sda_drive_low, busy, done, fail;
    logic scl_bus, sda_bus;

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    bit cmp_en = 1'b0;

    always #10 clk = ~clk;

    assign scl_bus = !(scl_drive_low === 1'b1 || ext_scl_hold);
    assign sda_bus = !(sda_drive_low === 1'b1 || stuck_forever || stuck_left > 0);

    i2c_bus_recover #(
        .CLK_PER_US (CPU), .STEP_US (SU), .QUIET_US (QU), .DEADLINE_US (DU)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .recover_req (recover_req),
        .scl_in (scl_bus), .sda_in (sda_bus),
        .scl_drive_low (scl_drive_low), .sda_drive_low (sda_drive_low),
        .busy (busy), .done (done), .fail (fail)
    );

    // Stuck slave: lets go of SDA after a set number of SCL rising edges.
    always @(posedge scl_bus) begin
        if (stuck_left > 0) stuck_left <= stuck_left - 1;
    end

    // Behavioural reference: phase number, cycles in phase, cycles since request.
    int m_ph = 0;
    int m_cnt = 0;
    int m_elapsed = 0;
    bit m_done = 0;
    bit m_fail = 0;

    always @(posedge clk) begin
        int nx;
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_elapsed = 0; m_done = 0; m_fail = 0;
        end else begin
            nx = m_ph;
            if (m_ph == 0) begin
                if (recover_req) begin
                    nx = 1; m_done = 0; m_fail = 0; m_elapsed = 0;
                end
            end else begin
                m_elapsed++;
                m_cnt++;
                if (m_elapsed == DL_C) begin
                    nx = 0; m_fail = 1;
                end else if (m_ph == 1) begin
                    if (scl_bus) nx = 2;
                end else if (m_ph == 8) begin
                    if (!scl_bus) nx = 1;
                    else if (m_cnt == QUIET_C) begin nx = 0; m_done = 1; end
                end else if (m_cnt == STEP_C) begin
                    if (m_ph == 2) nx = sda_bus ? 5 : 3;
                    else if (m_ph == 4) nx = 1;
                    else nx = m_ph + 1;
                end
            end
            if (nx != m_ph) m_cnt = 0;
            m_ph = nx;
        end
    end

    function automatic string tag_of(int ph);
        case (ph)
            0: return "R7";
            1: return "R2";
            2, 3, 4: return "R4";
            5, 6, 7: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Compare the ports with the reference on every cycle.
    always @(negedge clk) begin
        if (rst_n && cmp_en && !finished) begin
            int act, exp;
            act = {scl_drive_low, sda_drive_low, busy, done, fail};
            exp = {(m_ph == 3 || m_ph == 6), (m_ph >= 5 && m_ph <= 7), (m_ph != 0), m_done, m_fail};
            check(act == exp, tag_of(m_ph), "cycle compare {scl,sda,busy,done,fail}", act, exp);
        end
    end

    // Edge and length monitors on the drive outputs.
    int busy_cyc = 0;
    int scl_falls = 0;
    int sda_falls = 0;
    int scl_run = 0;
    int last_scl_len = 0;
    logic scl_prev = 1'b0;
    logic sda_prev = 1'b0;
    always @(negedge clk) begin
        if (busy === 1'b1) busy_cyc++;
        if (scl_drive_low === 1'b1 && !scl_prev) scl_falls++;
        if (sda_drive_low === 1'b1 && !sda_prev) sda_falls++;
        if (scl_drive_low === 1'b1) scl_run++;
        else if (scl_prev) begin last_scl_len = scl_run; scl_run = 0; end
        scl_prev = (scl_drive_low === 1'b1);
        sda_prev = (sda_drive_low === 1'b1);
    end

    task automatic clear_mon();
        busy_cyc = 0; scl_falls = 0; sda_falls = 0; last_scl_len = 0;
    endtask

    task automatic pulse_req();
        recover_req = 1'b1;
        @(negedge clk);
        recover_req = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy === 1'b1) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check({scl_drive_low, sda_drive_low, busy, done, fail} == 5'b0, "R1", "outputs after reset",
              {scl_drive_low, sda_drive_low, busy, done, fail}, 0);
        cmp_en = 1'b1;

        // R7/R5: clean bus, nominal length 1 + 4 steps + quiet window
        clear_mon();
        pulse_req();
        check(busy == 1'b1, "R2", "busy after request", busy, 1);
        wait_idle();
        check(busy_cyc == 1 + 4 * STEP_C + QUIET_C, "R7", "clean run busy cycles", busy_cyc, 1 + 4 * STEP_C + QUIET_C);
        check(done == 1'b1 && fail == 1'b0, "R7", "done after clean run", {done, fail}, 2);
        check(sda_falls == 1 && scl_falls == 1, "R5", "START/STOP drive edges", sda_falls * 10 + scl_falls, 11);
        repeat (50) @(negedge clk);
        check(done == 1'b1, "R7", "done held while idle", done, 1);

        // R4/R3: slave holds SDA for 4 pulses
        clear_mon();
        stuck_left = 4;
        pulse_req();
        check(done == 1'b0, "R2", "done cleared by new request", done, 0);
        wait_idle();
        check(done == 1'b1, "R4", "done after stuck SDA", done, 1);
        check(scl_falls == 5, "R4", "SCL low pulses (4 recovery + 1 STOP)", scl_falls, 5);
        check(last_scl_len == STEP_C, "R3", "SCL low step length", last_scl_len, STEP_C);

        // R2: SCL stretched by another agent at start
        clear_mon();
        ext_scl_hold = 1'b1;
        pulse_req();
        repeat (300) @(negedge clk);
        check(scl_drive_low == 1'b0 && sda_drive_low == 1'b0 && busy == 1'b1, "R2", "released while SCL held",
              {scl_drive_low, sda_drive_low, busy}, 1);
        ext_scl_hold = 1'b0;
        wait_idle();
        check(done == 1'b1 && scl_falls == 1, "R2", "completes after stretch", scl_falls, 1);

        // R6: SCL activity inside the quiet window restarts the procedure
        clear_mon();
        pulse_req();
        while (sda_drive_low !== 1'b1) @(negedge clk);
        while (sda_drive_low === 1'b1) @(negedge clk);
        repeat (30) @(negedge clk);
        ext_scl_hold = 1'b1;
        repeat (5) @(negedge clk);
        ext_scl_hold = 1'b0;
        wait_idle();
        check(sda_falls == 2, "R6", "START count after quiet restart", sda_falls, 2);
        check(done == 1'b1, "R6", "done after restart", done, 1);

        // R9: request during busy has no effect
        clear_mon();
        pulse_req();
        repeat (40) @(negedge clk);
        pulse_req();
        wait_idle();
        check(busy_cyc == 1 + 4 * STEP_C + QUIET_C, "R9", "run length with extra request", busy_cyc, 1 + 4 * STEP_C + QUIET_C);

        // R8: SCL held low for good
        clear_mon();
        ext_scl_hold = 1'b1;
        pulse_req();
        wait_idle();
        check(busy_cyc == DL_C, "R8", "deadline length, SCL held", busy_cyc, DL_C);
        check(fail == 1'b1 && done == 1'b0, "R8", "fail after SCL held", {done, fail}, 1);
        ext_scl_hold = 1'b0;

        // R8: SDA held low for good, deadline during the pulse loop
        clear_mon();
        stuck_forever = 1'b1;
        pulse_req();
        wait_idle();
        check(busy_cyc == DL_C, "R8", "deadline length, SDA held", busy_cyc, DL_C);
        check(fail == 1'b1 && scl_drive_low == 1'b0 && sda_drive_low == 1'b0, "R8", "released after fail",
              {fail, scl_drive_low, sda_drive_low}, 4);
        stuck_forever = 1'b0;
        repeat (5) @(negedge clk);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule